// File: doc/BRIEF.md
# Serial Converter Result Reader

This block is the host side of a read-only, two-wire link to a sigma-delta converter. The converter has one output line that does two jobs: it drops low when a new conversion is waiting, and it then carries the result bits. The host drives a serial clock that idles high. The block watches the line through a two-flop synchronizer. Once it has seen the line high and then low, it reads a 32-bit frame. Each serial clock low phase and high phase lasts a set number of system clocks, given as parameters. The block captures one bit at the end of each high phase, most significant bit first.

The frame holds a 20-bit offset-binary result, four padding bits and a status byte. The block accepts the frame only when the status byte matches the expected pattern. An accepted frame becomes a signed two's-complement result on a valid/ready output, with the gain, rate and converter-error bits alongside it. A rejected frame is dropped, sets a sticky flag, and the block waits for the next conversion. While a result is still waiting to be taken, no new read starts, so the consumer sets the pace. The whole read has to finish inside one converter update period.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `sclk_o` is 1, `res_valid_o` is 0 and `frame_err_o` is 0.
- R2: A read starts only after the synchronized line has been seen high and then low. A line that is already low when reset ends starts no read until it has gone high and then low again.
- R3: Each read makes exactly 32 serial clock pulses. Every low phase lasts `LO_CYC` system clocks, and the 31 high phases between pulses last `HI_CYC` system clocks. The clock stays high between reads.
- R4: The block captures one bit from the line at the end of each high phase, first bit as bit 31. The frame layout is:
  - bits 31..12: the result.
  - bits 11..8: padding.
  - status byte: bit 7 is the ready bit, bit 6 is the rate bit, bit 5 is the converter-error bit, bits 4..3 are the identity, bit 2 is the gain bit and bits 1..0 are the pattern.
- R5: A frame is accepted only if all of these hold: the padding is zero, the ready bit is 0, the identity equals `EXP_ID` (default 00), and the pattern is 00. Only an accepted frame raises `res_valid_o`.
- R6: A rejected frame produces no output and sets `frame_err_o`, which stays 1 until reset. The block then reads later frames normally.
- R7: `res_data_o` is the 20-bit result with its top bit inverted (two's complement). Raw 0x80000 gives 0, raw 0xFFFFF gives 0x7FFFF, and raw 0x00000 gives 0x80000 (the most negative value).
- R8: `res_gain_o`, `res_rate_o` and `res_err_o` carry status bits 2, 6 and 5 of the accepted frame.
- R9: `res_valid_o` stays 1, with all result fields unchanged, until a cycle with `res_ready_i` = 1. In the next cycle it is 0.
- R10: While `res_valid_o` is 1, no read starts even if the line is low. The waiting conversion is read after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| line_i | input | 1 | Shared ready/data line from the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| res_valid_o | output | 1 | A result is waiting |
| res_ready_i | input | 1 | Consumer takes the result |
| res_data_o | output | 20 | Signed result |
| res_gain_o | output | 1 | Gain status bit of the result |
| res_rate_o | output | 1 | Rate status bit of the result |
| res_err_o | output | 1 | Converter-error status bit of the result |
| frame_err_o | output | 1 | Sticky flag: a frame was rejected |

## Verification
A wrong bit count or a wrong phase timer shows on `sclk_o` within the read it affects. The edge count or a phase length changes, and the frame is shifted by one place, which shows in the next result or as a false reject. A wrong accept rule or a wrong field position shows one cycle after the last pulse, either as a missing or extra `res_valid_o` or as a wrong sideband or data value. A fault in the hold or pending logic shows as `sclk_o` moving, or as the data changing, while a result is still waiting.

// File: rtl/afr_pkg.sv
package afr_pkg;

    localparam int PAD_W  = 4;
    localparam int STAT_W = 8;

    // status byte bit positions (decoded by the checker)
    localparam int ST_RDY    = 7;
    localparam int ST_RATE   = 6;
    localparam int ST_ERR    = 5;
    localparam int ST_ID_LO  = 3;
    localparam int ST_GAIN   = 2;
    localparam int ST_PAT_LO = 0;

    typedef enum logic [1:0] {
        ENG_ARM,
        ENG_WAIT,
        ENG_LOW,
        ENG_HIGH
    } eng_state_e;

endpackage

// File: rtl/afr_sync.sv
module afr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t d, q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb begin
                d = q;
                d.chain = d_i;
            end
        end else begin : g_many
            always_comb begin
                d = q;
                d.chain = {q.chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign q_o = q.chain[STAGES-1];

endmodule

// File: rtl/afr_shift_engine.sv
module afr_shift_engine
    import afr_pkg::*;
#(
    parameter int LO_CYC  = 13,
    parameter int HI_CYC  = 13,
    parameter int FRAME_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               line_s_i,
    input  logic               out_free_i,
    output logic               sclk_o,
    output logic [FRAME_W-1:0] word_o,
    output logic               stb_o
);
    localparam int MAX_CYC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [TMR_W-1:0] LO_LOAD  = TMR_W'(LO_CYC - 1);
    localparam logic [TMR_W-1:0] HI_LOAD  = TMR_W'(HI_CYC - 1);

    typedef struct packed {
        eng_state_e         st;
        logic               sclk;
        logic [TMR_W-1:0]   tmr;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        logic               stb;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d = q;
        d.stb = 1'b0;
        unique case (q.st)
            ENG_ARM: begin
                if (line_s_i) d.st = ENG_WAIT;
            end
            ENG_WAIT: begin
                if (!line_s_i && out_free_i) begin
                    d.st   = ENG_LOW;
                    d.sclk = 1'b0;
                    d.tmr  = LO_LOAD;
                    d.cnt  = '0;
                end
            end
            ENG_LOW: begin
                if (q.tmr == '0) begin
                    d.st   = ENG_HIGH;
                    d.sclk = 1'b1;
                    d.tmr  = HI_LOAD;
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            ENG_HIGH: begin
                if (q.tmr == '0) begin
                    d.sh = {q.sh[FRAME_W-2:0], line_s_i};
                    if (q.cnt == LAST_BIT) begin
                        d.st  = ENG_ARM;
                        d.stb = 1'b1;
                    end else begin
                        d.cnt  = q.cnt + 1'b1;
                        d.st   = ENG_LOW;
                        d.sclk = 1'b0;
                        d.tmr  = LO_LOAD;
                    end
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            default: d.st = ENG_ARM;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.st   <= ENG_ARM;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk_o = q.sclk;
    assign word_o = q.sh;
    assign stb_o  = q.stb;

    // checker-only counters: phase length and rising edges per frame
    logic [31:0] ph_len_q;
    logic [7:0]  rise_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_len_q   <= '0;
            rise_cnt_q <= '0;
        end else begin
            ph_len_q <= (d.sclk != q.sclk) ? 32'd0 : ph_len_q + 32'd1;
            if (q.st == ENG_WAIT)          rise_cnt_q <= '0;
            else if (!q.sclk && d.sclk)    rise_cnt_q <= rise_cnt_q + 8'd1;
        end
    end

    AST_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!q.sclk && d.sclk) |-> ph_len_q == 32'(LO_CYC - 1)); // R3
    AST_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ENG_HIGH && q.sclk && !d.sclk) |-> ph_len_q == 32'(HI_CYC - 1)); // R3
    AST_FRAME_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.stb |-> rise_cnt_q == 8'(FRAME_W)); // R3
    AST_START_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ENG_LOW && $past(q.st) == ENG_WAIT) |-> $past(!line_s_i && out_free_i)); // R2

endmodule

// File: rtl/afr_frame_check.sv
module afr_frame_check
    import afr_pkg::*;
#(
    parameter int         RES_W   = 20,
    parameter int         FRAME_W = 32,
    parameter logic [1:0] EXP_ID  = 2'b00
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [FRAME_W-1:0] word_i,
    input  logic               stb_i,
    input  logic               ready_i,
    output logic               valid_o,
    output logic [RES_W-1:0]   data_o,
    output logic               gain_o,
    output logic               rate_o,
    output logic               err_o,
    output logic               sticky_o,
    output logic               out_free_o
);
    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] data;
        logic             gain;
        logic             rate;
        logic             err;
        logic             sticky;
    } chk_t;

    chk_t d, q;

    logic [RES_W-1:0]  raw_res;
    logic [PAD_W-1:0]  pad;
    logic [STAT_W-1:0] stat;
    logic              good;

    assign raw_res = word_i[FRAME_W-1 -: RES_W];
    assign pad     = word_i[STAT_W +: PAD_W];
    assign stat    = word_i[STAT_W-1:0];
    assign good    = (pad == '0) && !stat[ST_RDY]
                   && (stat[ST_ID_LO +: 2] == EXP_ID)
                   && (stat[ST_PAT_LO +: 2] == 2'b00);

    always_comb begin
        d = q;
        if (q.valid && ready_i) d.valid = 1'b0;
        if (stb_i) begin
            if (good) begin
                d.valid = 1'b1;
                d.data  = {~raw_res[RES_W-1], raw_res[RES_W-2:0]};
                d.gain  = stat[ST_GAIN];
                d.rate  = stat[ST_RATE];
                d.err   = stat[ST_ERR];
            end else begin
                d.sticky = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign valid_o    = q.valid;
    assign data_o     = q.data;
    assign gain_o     = q.gain;
    assign rate_o     = q.rate;
    assign err_o      = q.err;
    assign sticky_o   = q.sticky;
    assign out_free_o = !q.valid;

    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.valid && !ready_i) |=> (q.valid && $stable(q.data) && $stable(q.gain))); // R9
    AST_STICKY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.sticky |=> q.sticky); // R6
    AST_VALID_FROM_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.valid) |-> $past(stb_i)); // R5
    AST_ERR_FROM_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.sticky) |-> $past(stb_i)); // R6

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import afr_pkg::*;
#(
    parameter int         LO_CYC      = 13,
    parameter int         HI_CYC      = 13,
    parameter int         SYNC_STAGES = 2,
    parameter int         RES_W       = 20,
    parameter logic [1:0] EXP_ID      = 2'b00
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             line_i,
    output logic             sclk_o,
    output logic             res_valid_o,
    input  logic             res_ready_i,
    output logic [RES_W-1:0] res_data_o,
    output logic             res_gain_o,
    output logic             res_rate_o,
    output logic             res_err_o,
    output logic             frame_err_o
);
    localparam int FRAME_W = RES_W + PAD_W + STAT_W;

    logic               line_s;
    logic               out_free;
    logic [FRAME_W-1:0] word;
    logic               stb;

    afr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (line_i),
        .q_o   (line_s)
    );

    afr_shift_engine #(
        .LO_CYC (LO_CYC),
        .HI_CYC (HI_CYC),
        .FRAME_W(FRAME_W)
    ) u_eng (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .line_s_i  (line_s),
        .out_free_i(out_free),
        .sclk_o    (sclk_o),
        .word_o    (word),
        .stb_o     (stb)
    );

    afr_frame_check #(
        .RES_W  (RES_W),
        .FRAME_W(FRAME_W),
        .EXP_ID (EXP_ID)
    ) u_chk (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .word_i    (word),
        .stb_i     (stb),
        .ready_i   (res_ready_i),
        .valid_o   (res_valid_o),
        .data_o    (res_data_o),
        .gain_o    (res_gain_o),
        .rate_o    (res_rate_o),
        .err_o     (res_err_o),
        .sticky_o  (frame_err_o),
        .out_free_o(out_free)
    );

    AST_QUIET_WHILE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |-> sclk_o); // R10

endmodule

// File: tb/tb_adc_frame_reader.sv
`timescale 1ns/1ps
module tb_adc_frame_reader;
    localparam int LO = 13;
    localparam int HI = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line = 1'b0;
    logic        ready = 1'b0;
    logic        sclk, valid, gain, rate, err, ferr;
    logic [19:0] data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_frame_reader #(.LO_CYC(LO), .HI_CYC(HI)) dut (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line), .sclk_o(sclk),
        .res_valid_o(valid), .res_ready_i(ready), .res_data_o(data),
        .res_gain_o(gain), .res_rate_o(rate), .res_err_o(err),
        .frame_err_o(ferr)
    );

    // serial clock monitor, sampled away from the active edge
    int  fall_cnt = 0, lo_bad = 0, hi_ok = 0, run = 0;
    logic prev = 1'b1;
    always @(negedge clk) begin
        if (sclk == prev) run++;
        else begin
            if (!prev && run != LO) lo_bad++;
            if (prev && run == HI) hi_ok++;
            if (prev) fall_cnt++;
            run = 1;
        end
        prev = sclk;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog expired act=%0d exp<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic serve_bits(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) begin
            @(negedge sclk);
            #2 line = w[i];
            @(posedge sclk);
        end
        repeat (20) @(posedge clk);
        line = 1'b1;
    endtask

    // frame words; expectation = {good, data[19:0], gain, rate, err}
    localparam int NV = 9;
    localparam logic [31:0] V_WORD [NV] = '{
        32'h8000_0000, 32'hFFFF_F044, 32'h0000_0020, 32'h1234_5064,
        32'hABCD_E001, 32'h5555_5008, 32'h3333_3080, 32'h7FFF_F100,
        32'h7FFF_F004
    };
    localparam logic [23:0] V_EXP [NV] = '{
        {1'b1, 20'h00000, 3'b000}, {1'b1, 20'h7FFFF, 3'b110},
        {1'b1, 20'h80000, 3'b001}, {1'b1, 20'h92345, 3'b111},
        {1'b0, 20'h00000, 3'b000}, {1'b0, 20'h00000, 3'b000},
        {1'b0, 20'h00000, 3'b000}, {1'b0, 20'h00000, 3'b000},
        {1'b1, 20'hFFFFF, 3'b100}
    };

    task automatic ack();
        @(negedge clk) ready = 1'b1;
        @(negedge clk) ready = 1'b0;
        check(valid == 1'b0, "R9 valid drops after handshake", valid, 0);
    endtask

    initial begin
        bit sticky_exp = 1'b0;
        int f0, h0, l0;
        // R1 and R2: line held low through reset and beyond
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk == 1'b1, "R1 sclk idle", sclk, 1);
        check(valid == 1'b0, "R1 valid low", valid, 0);
        check(ferr == 1'b0, "R1 error flag low", ferr, 0);
        repeat (100) @(negedge clk);
        check(fall_cnt == 0, "R2 no read without high-to-low", fall_cnt, 0);
        line = 1'b1;
        repeat (10) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            f0 = fall_cnt; h0 = hi_ok; l0 = lo_bad;
            line = 1'b0;
            serve_bits(V_WORD[i]);
            repeat (10) @(negedge clk);
            check(fall_cnt - f0 == 32, "R3 pulse count", fall_cnt - f0, 32);
            check(hi_ok - h0 == 31 && lo_bad == l0, "R3 phase widths", hi_ok - h0, 31);
            if (V_EXP[i][23]) begin
                check(valid == 1'b1, "R5 accepted frame valid", valid, 1);
                check(data == V_EXP[i][22:3], "R4 R7 result data", data, V_EXP[i][22:3]);
                check({gain, rate, err} == V_EXP[i][2:0], "R8 sideband bits",
                      {gain, rate, err}, V_EXP[i][2:0]);
            end else begin
                sticky_exp = 1'b1;
                check(valid == 1'b0, "R5 rejected frame gives no output", valid, 0);
            end
            check(ferr == sticky_exp, "R6 sticky error flag", ferr, sticky_exp);
            if (valid) ack();
        end

        // R9 hold and R10 no read while pending
        line = 1'b0;
        serve_bits(32'h4000_0044);
        @(negedge clk);
        check(valid == 1'b1 && data == 20'hC0000, "R7 pending result", data, 20'hC0000);
        f0 = fall_cnt;
        line = 1'b0;
        repeat (200) @(negedge clk);
        check(fall_cnt == f0, "R10 no read while result pending", fall_cnt - f0, 0);
        check(valid == 1'b1 && data == 20'hC0000 && gain && rate,
              "R9 result held stable", data, 20'hC0000);
        ack();
        serve_bits(32'hC000_0000);
        repeat (10) @(negedge clk);
        check(fall_cnt - f0 == 32, "R10 waiting frame read after handshake", fall_cnt - f0, 32);
        check(valid == 1'b1 && data == 20'h40000, "R10 waiting frame data", data, 20'h40000);
        check(ferr == 1'b1, "R6 flag still set", ferr, 1);
        ack();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule